// File: doc/BRIEF.md
# EEPROM Page-Write Load Controller

This block models the write side of a byte-alterable parallel EEPROM at the cycle level. A host issues byte writes and reads on a synchronous strobe interface that carries a 15-bit address and an 8-bit data byte. The upper eight address bits name a 128-byte page and the lower seven bits pick a byte inside it. The first write opens a page. Further writes to the same page are gathered in a local buffer. Each byte is marked in a per-byte valid mask.

The page closes on its own when no new byte arrives within the load window. That window is counted in ticks of a clock-enable input. The block then goes busy and scans the buffer. It writes only the marked bytes to an external array write port, one slot per clock. Busy also lasts for a minimum programming time, counted in ticks. While busy, reads do not reach the array and return a status byte instead. Bit 7 of that byte flags the last byte written, and bit 6 alternates on each read. When busy ends, the mask is cleared and reads return array data again.

Top module: `eeprom_page_loader`

## Requirements
- R1: After reset, busy, arr_we and rvalid are all low.
- R2: A byte written at address A appears in the array at address A once programming ends. Bits 14:7 of A are the page and bits 6:0 are the offset. If one offset is loaded twice, the last value is kept.
- R3: With tick high every cycle, busy rises on the WIN_TICKS-th clock edge after the edge that accepted the last load. Every accepted load restarts this count.
- R4: Loads spaced closer than the window keep the page open with no overall time limit, and busy stays low the whole time.
- R5: While a page is open, a write whose bits 14:7 differ from the open page is dropped and never reaches the array.
- R6: Each programming period issues exactly one array write per distinct loaded offset. Offsets that were not loaded keep their old contents. The mask is empty when busy falls, so a later page rewrites only its own bytes.
- R7: Writes made while busy are ignored, and they do not start a new programming period.
- R8: Busy lasts at least PROG_TICKS ticks and no longer than the larger of PROG_TICKS and the page scan, plus a few cycles. Afterwards, reads return true array data.
- R9: A busy read of the last address written returns the complement of that byte's bit 7 on bit 7. A busy read of any other address returns 0 on bit 7. Bits 5:0 of a busy read are 0.
- R10: Bit 6 of busy reads starts at 0 in each programming period and inverts on every following busy read.
- R11: rvalid goes high exactly one cycle after rd_en. When not busy, rdata then holds the array byte at the requested address.
- R12: While tick is low, the load window does not advance, so an open page stays open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable that times the window and programming |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 15 | Byte address, page in 14:7 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |
| rvalid | output | 1 | rdata valid, one cycle after rd_en |
| busy | output | 1 | Programming in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 15 | Array address: the scan address while busy, otherwise addr |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data for arr_addr |

## Verification
The bench targets four failure cases:
- **Timeout edge.** A window off by one tick would raise busy a cycle early or late.
- **Foreign-page write inside an open page.** If that write were accepted, it would overwrite a byte of the locked page.
- **Stale valid mask.** A second page to the same page address would then rewrite the earlier bytes, and the array write count would be too high.
- **Status byte during busy.** The bench reads both the last address and an unrelated one, and also writes while busy. A wrong toggle phase, a missing complement, or an accepted busy write each shows up as a wrong read-back value or as a busy period starting again.

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int OFFW = 7,
  parameter int WIN_TICKS = 4,
  parameter int PROG_TICKS = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          busy,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  input  logic [DW-1:0] arr_rdata
);
  localparam int PAGE = 1 << OFFW;
  localparam int PGW  = AW - OFFW;
  localparam int WCW  = $clog2(WIN_TICKS + 1);
  localparam int PCW  = $clog2(PROG_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t             st;
  logic [PGW-1:0]  page_q;
  logic [AW-1:0]   last_addr;
  logic [DW-1:0]   last_data;
  logic [PAGE-1:0] vmask;
  logic [DW-1:0]   pbuf [PAGE];
  logic [WCW-1:0]  win_cnt;
  logic [PCW-1:0]  prog_cnt;
  logic            tmr_done;
  logic [OFFW-1:0] scan_idx;
  logic            scan_done;
  logic            tog;

  wire [OFFW-1:0] off     = addr[OFFW-1:0];
  wire            same_pg = addr[AW-1:OFFW] == page_q;
  wire            take    = wr_en && (st == S_IDLE || (st == S_LOAD && same_pg));
  wire            win_end = st == S_LOAD && !take && tick && win_cnt == WCW'(WIN_TICKS - 1);
  wire            p_exit  = st == S_PROG && scan_done && tmr_done;
  wire            hit     = addr == last_addr;
  wire [DW-1:0]   stat    = {hit & ~last_data[DW-1], tog, {(DW-2){1'b0}}};

  assign busy      = st == S_PROG;
  assign arr_we    = busy && !scan_done && vmask[scan_idx];
  assign arr_addr  = busy ? {page_q, scan_idx} : addr;
  assign arr_wdata = pbuf[scan_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (take) st <= S_LOAD;
        S_LOAD:  if (win_end) st <= S_PROG;
        S_PROG:  if (p_exit) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      page_q    <= '0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      if (take) begin
        win_cnt   <= '0;
        last_addr <= addr;
        last_data <= wdata;
        if (st == S_IDLE) page_q <= addr[AW-1:OFFW];
      end else if (st == S_LOAD && tick) begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vmask <= '0;
    else if (take) vmask[off] <= 1'b1;
    else if (p_exit) vmask <= '0;
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[off] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != S_PROG) begin
      scan_idx  <= '0;
      scan_done <= 1'b0;
      prog_cnt  <= '0;
      tmr_done  <= 1'b0;
    end else begin
      if (!scan_done) begin
        scan_idx <= scan_idx + 1'b1;
        if (scan_idx == OFFW'(PAGE - 1)) scan_done <= 1'b1;
      end
      if (tick && !tmr_done) begin
        prog_cnt <= prog_cnt + 1'b1;
        if (prog_cnt == PCW'(PROG_TICKS - 1)) tmr_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      tog    <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (!busy) tog <= 1'b0;
      else if (rd_en) tog <= ~tog;
      if (rd_en) rdata <= busy ? stat : arr_rdata;
    end
  end

  logic [PCW-1:0] chk_ticks;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) chk_ticks <= '0;
    else if (tick && chk_ticks < PCW'(PROG_TICKS)) chk_ticks <= chk_ticks + 1'b1;
  end

  p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  p_foreign_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && wr_en && !same_pg) |=> $stable(vmask));

  p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> vmask == '0);

  p_busy_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(last_addr));

  p_busy_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> chk_ticks >= PCW'(PROG_TICKS));

  p_stat_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(rd_en) && $past(busy)) |-> rdata[DW-3:0] == '0);
endmodule

// File: tb/eeprom_page_loader_tb.sv
module eeprom_page_loader_tb_top;
  localparam int WIN  = 6;
  localparam int PROG = 200;
  localparam int PAGE = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        busy;
  logic        arr_we;
  logic [14:0] arr_addr;
  logic [7:0]  arr_wdata;
  logic [7:0]  arr_rdata = 8'hFF;

  always #5 clk = ~clk;

  eeprom_page_loader #(.AW(15), .DW(8), .OFFW(7), .WIN_TICKS(WIN), .PROG_TICKS(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata));

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  bit done = 0;

  logic [7:0] amem [int];

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    if (amem.exists(int'(a))) return amem[int'(a)];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (arr_we) begin
      amem[int'(arr_addr)] = arr_wdata;
      we_cnt++;
    end
  end

  always begin
    @(negedge clk);
    #2;
    arr_rdata = mem_rd(arr_addr);
  end

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rvalid && rst_n) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R11 unexpected rvalid", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(rdata == it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    sb_q.push_back('{exp: e, tag: tag});
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hi(input string tag);
    int n = 0;
    while (!busy && n < 5000) begin @(negedge clk); n++; end
    chk(busy, tag, busy, 1);
  endtask

  task automatic wait_lo(output int len);
    len = 0;
    while (busy && len < 5000) begin @(negedge clk); len++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int len;
    idle(3);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(arr_we == 0, "R1 arr_we", arr_we, 0);
    chk(rvalid == 0, "R1 rvalid", rvalid, 0);
    rst_n = 1'b1;
    idle(2);

    // Single byte: window timing, busy length, unloaded neighbour untouched
    we_cnt = 0;
    wr(15'h0A05, 8'h5A);
    idle(WIN - 1);
    chk(busy == 0, "R3 before expiry", busy, 0);
    idle(1);
    chk(busy == 1, "R3 at expiry", busy, 1);
    wait_lo(len);
    chk(len >= PROG && len <= PROG + PAGE + 4, "R8 busy length", len, PROG);
    chk(we_cnt == 1, "R6 write count single", we_cnt, 1);
    rd(15'h0A05, 8'h5A, "R2 single byte readback");
    rd(15'h0A06, 8'hFF, "R6 unloaded neighbour");

    // Long page with a repeated offset and a foreign page write
    we_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      wr({8'h0B, 7'(i + 3)}, 8'h10 + 8'(i));
      if (i == 4) wr(15'h0C00, 8'hEE);
      if (i == 6) wr({8'h0B, 7'd3}, 8'hA3);
      idle(1);
    end
    chk(busy == 0, "R4 page still open", busy, 0);
    wait_hi("R4 page eventually closes");
    wait_lo(len);
    chk(we_cnt == 10, "R6 write count page", we_cnt, 10);
    rd({8'h0B, 7'd3}, 8'hA3, "R2 last value wins");
    for (int i = 1; i < 10; i++) rd({8'h0B, 7'(i + 3)}, 8'h10 + 8'(i), "R2 page readback");
    rd(15'h0C00, 8'hFF, "R5 foreign page dropped");

    // Status reads during busy; write while busy
    wr(15'h0D10, 8'h3C);
    wait_hi("R3 close before status");
    rd(15'h0D10, 8'h80, "R9 complement bit7");
    rd(15'h0D10, 8'hC0, "R10 toggle second");
    wr(15'h0D11, 8'h77);
    rd(15'h0111, 8'h00, "R10 toggle third other addr");
    rd(15'h0D10, 8'hC0, "R10 toggle fourth");
    wait_lo(len);
    rd(15'h0D10, 8'h3C, "R8 true data after busy");
    rd(15'h0D11, 8'hFF, "R7 busy write ignored");
    idle(30);
    chk(busy == 0, "R7 no new programming", busy, 0);

    // Bit 7 set in the last byte; toggle restarts at 0
    wr(15'h0E00, 8'h9F);
    wait_hi("R3 close before status 2");
    rd(15'h0E00, 8'h00, "R9 complement of one");
    rd(15'h0E01, 8'h40, "R10 toggle restarts");
    wait_lo(len);

    // No ticks: window frozen
    tick = 1'b0;
    wr(15'h0F01, 8'h11);
    idle(40);
    chk(busy == 0, "R12 frozen window", busy, 0);
    tick = 1'b1;
    wait_hi("R12 closes after ticks resume");
    wait_lo(len);
    rd(15'h0F01, 8'h11, "R2 after frozen window");

    // Same page again: mask cleared
    we_cnt = 0;
    wr(15'h0F02, 8'h22);
    wait_hi("R3 second visit");
    wait_lo(len);
    chk(we_cnt == 1, "R6 mask cleared", we_cnt, 1);
    rd(15'h0F01, 8'h11, "R6 earlier byte kept");
    rd(15'h0F02, 8'h22, "R11 plain read");
    idle(3);
    chk(sb_q.size() == 0, "R11 all reads answered", sb_q.size(), 0);
    finish_run();
  end
endmodule